// File: doc/BRIEF.md
# ADC serial interface power-mode controller

This block is the digital half of a 10-bit sampling converter's three-wire serial port. A host lowers the convert-start line (`cnv_n`), clocks the serial clock (`sck`), and reads the conversion result from a data line that is driven only while a frame is open. The analog sampler is replaced by a parallel `sample` input, which is captured when a frame opens. All port activity is sampled in the system clock domain through a synchronizer. Every action therefore takes place a fixed number of system clocks after the pin edge that causes it.

The host picks the power state by choosing when it raises convert-start. A frame cut short in the middle sends a running converter into partial power-down, where the reference stays on. A second short frame sends it into full power-down, where the reference is switched off. Only a long frame brings the converter back to normal operation. When the block leaves full power-down, a recovery timer holds `ready` low so that the reference has time to settle. Results from frames that open during that time carry an invalid flag. A parameter selects whether the result is sent as straight binary or as two's complement.

Top module: `adc_sif_ctrl`

## Requirements
- R1: `sdo_oe` is 0 whenever convert-start is high. It falls no later than 3 system clocks after `cnv_n` rises, and it is 1 from 3 clocks after `cnv_n` falls until the frame closes.
- R2: In frame bit position p (p = number of falling `sck` edges since the frame opened, 0..15), `sdo` carries bit 15-p of the word {3'b000, code[9:0], S1, 1'b0, 1'b0}. Bit positions past the end of the frame read 0. The host samples the line on each rising `sck` edge.
- R3: In normal mode (`mode`=2'b00), a frame closed after 4 to 13 rising `sck` edges moves the block to partial power-down (`mode`=2'b01), and `ref_en` stays 1.
- R4: In normal mode, a frame closed after 0 to 3 rising edges, or after 14 or more, leaves the mode at normal.
- R5: In partial power-down, a frame closed after 4 to 13 rising edges moves the block to full power-down (`mode`=2'b10). There `ref_en` is 0 and `ready` is 0.
- R6: In full power-down, a frame closed after fewer than 14 rising edges leaves the mode at full power-down.
- R7: In full power-down, a frame closed after 14 or more rising edges returns the block to normal with `ref_en` = 1. `ready` then stays 0 for REC_CYCLES system clocks and rises after that.
- R8: S1 is 1 when the frame opened while `ready` was 0, and 0 otherwise.
- R9: When BIPOLAR=0, code equals the captured sample. When BIPOLAR=1, code is the sample with its MSB inverted, which is the two's-complement form.
- R10: The sample is captured when convert-start falls. Later changes to `sample` do not affect the frame being sent.
- R11: In partial power-down, a frame closed after 0 to 3 rising edges leaves the mode at partial. A frame closed after 14 or more returns it to normal with `ready` still 1.
- R12: After reset: `mode`=2'b00, `ref_en`=1, `ready`=1, `sdo_oe`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cnv_n | input | 1 | Convert-start; a low level opens a frame and the rising edge closes it |
| sck | input | 1 | Serial clock from the host |
| sample | input | DATA_W | Parallel conversion result standing in for the sampler |
| sdo | output | 1 | Serial data bit |
| sdo_oe | output | 1 | Data line drive enable (0 = high impedance) |
| mode | output | 2 | Power state: 00 normal, 01 partial, 10 full |
| ref_en | output | 1 | Reference enable |
| ready | output | 1 | Results valid; low during recovery and in full power-down |

## Verification
Two events can fall in the same system cycle. One is a frame opening: it captures the sample and S1. The other is the last cycle of the recovery countdown. On that edge `ready`, as S1 sees it, is about to change. The bench opens frames straight after a long exit frame, while the countdown is running, and expects S1=1. It then probes `ready` 20 clocks before and 10 clocks after the nominal expiry, and finally opens a frame once recovery is over and expects S1=0. A second overlap is convert-start rising on the same cycle as a serial-clock edge. The bench sweeps every close point from 0 to 16 rising edges from each of the three modes, so the classification boundaries at 3/4 and 13/14 are both exercised.

// File: rtl/adc_sif_pkg.sv
package adc_sif_pkg;

    localparam int RISE_W = 8;

    typedef enum logic [1:0] {
        PM_NORMAL  = 2'b00,
        PM_PARTIAL = 2'b01,
        PM_FULL    = 2'b10
    } pmode_e;

    typedef enum logic [1:0] {
        FK_IGNORE = 2'b00,
        FK_SHORT  = 2'b01,
        FK_LONG   = 2'b10
    } fkind_e;

    typedef struct packed {
        logic              done;
        logic [RISE_W-1:0] rises;
    } frame_end_t;

    function automatic fkind_e classify(input logic [RISE_W-1:0] n,
                                        input logic [RISE_W-1:0] short_min,
                                        input logic [RISE_W-1:0] long_min);
        if (n >= long_min)       return FK_LONG;
        else if (n >= short_min) return FK_SHORT;
        else                     return FK_IGNORE;
    endfunction

    function automatic pmode_e next_mode(input pmode_e cur, input fkind_e k);
        pmode_e nm;
        nm = cur;
        case (cur)
            PM_NORMAL:  if (k == FK_SHORT) nm = PM_PARTIAL;
            PM_PARTIAL: if (k == FK_SHORT) nm = PM_FULL;
                        else if (k == FK_LONG) nm = PM_NORMAL;
            PM_FULL:    if (k == FK_LONG) nm = PM_NORMAL;
            default:    nm = PM_NORMAL;
        endcase
        return nm;
    endfunction

endpackage

// File: rtl/adc_sif_sync.sv
module adc_sif_sync #(
    parameter int              W       = 2,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] level,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    genvar b;
    generate
        for (b = 0; b < W; b++) begin : g_bit
            logic [STAGES-1:0] chain;
            logic              prev;
            always_ff @(posedge clk) begin
                if (rst) begin
                    chain <= {STAGES{RST_VAL[b]}};
                    prev  <= RST_VAL[b];
                end else begin
                    chain <= {chain[STAGES-2:0], din[b]};
                    prev  <= chain[STAGES-1];
                end
            end
            assign level[b] = chain[STAGES-1];
            assign rise[b]  = chain[STAGES-1] & ~prev;
            assign fall[b]  = ~chain[STAGES-1] & prev;
        end
    endgenerate
endmodule

// File: rtl/adc_sif_frame.sv
module adc_sif_frame
    import adc_sif_pkg::*;
#(
    parameter int DATA_W    = 10,
    parameter int LEAD_BITS = 3,
    parameter int FRAME_LEN = 16,
    parameter bit BIPOLAR   = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_rise,
    input  logic              cs_fall,
    input  logic              sck_rise,
    input  logic              sck_fall,
    input  logic [DATA_W-1:0] sample,
    input  logic              invalid,
    output logic              sdo,
    output logic              sdo_oe,
    output frame_end_t        fend
);
    localparam int TAIL  = FRAME_LEN - LEAD_BITS - DATA_W;
    localparam int POS_W = $clog2(FRAME_LEN + 1);
    localparam int IDX_W = $clog2(FRAME_LEN);
    localparam logic [RISE_W-1:0] RISE_MAX = '1;

    logic                 active;
    logic [POS_W-1:0]     pos;
    logic [RISE_W-1:0]    rises;
    logic [FRAME_LEN-1:0] word;
    logic                 done;
    logic [DATA_W-1:0]    code;
    logic [FRAME_LEN-1:0] word_nx;
    logic [POS_W-1:0]     idx;

    generate
        if (BIPOLAR) begin : g_twos
            assign code = sample ^ (DATA_W'(1) << (DATA_W - 1));
        end else begin : g_straight
            assign code = sample;
        end
    endgenerate

    always_comb begin
        word_nx = (FRAME_LEN'(code) << TAIL) | (FRAME_LEN'(invalid) << (TAIL - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            pos    <= '0;
            rises  <= '0;
            word   <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (cs_fall) begin
                active <= 1'b1;
                pos    <= '0;
                rises  <= '0;
                word   <= word_nx;
            end else if (cs_rise) begin
                done   <= active;
                active <= 1'b0;
            end else if (active) begin
                if (sck_rise && rises != RISE_MAX) rises <= rises + 1'b1;
                if (sck_fall && pos != POS_W'(FRAME_LEN)) pos <= pos + 1'b1;
            end
        end
    end

    assign idx    = POS_W'(FRAME_LEN - 1) - pos;
    assign sdo    = (active && pos < POS_W'(FRAME_LEN)) ? word[idx[IDX_W-1:0]] : 1'b0;
    assign sdo_oe = active;
    assign fend.done  = done;
    assign fend.rises = rises;

    AST_OE_DROP:  assert property (@(posedge clk) disable iff (rst)
                      cs_rise |=> !sdo_oe);                          // R1
    AST_POS_OPEN: assert property (@(posedge clk) disable iff (rst)
                      cs_fall |=> (sdo_oe && pos == '0 && rises == '0)); // R2
    AST_WORD_HOLD: assert property (@(posedge clk) disable iff (rst)
                      (active && !cs_fall) |=> $stable(word));        // R10
endmodule

// File: rtl/adc_sif_pwr.sv
module adc_sif_pwr
    import adc_sif_pkg::*;
#(
    parameter int SHORT_MIN  = 4,
    parameter int LONG_MIN   = 14,
    parameter int REC_CYCLES = 200000
) (
    input  logic       clk,
    input  logic       rst,
    input  frame_end_t fend,
    output pmode_e     mode,
    output logic       ref_en,
    output logic       ready
);
    localparam int REC_W = $clog2(REC_CYCLES + 1);
    localparam logic [RISE_W-1:0] SMIN = RISE_W'(SHORT_MIN);
    localparam logic [RISE_W-1:0] LMIN = RISE_W'(LONG_MIN);

    pmode_e           mode_q;
    logic [REC_W-1:0] rec_cnt;
    fkind_e           kind;
    pmode_e           mode_nx;

    assign kind    = classify(fend.rises, SMIN, LMIN);
    assign mode_nx = next_mode(mode_q, kind);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= PM_NORMAL;
            rec_cnt <= '0;
        end else begin
            if (fend.done) mode_q <= mode_nx;
            if (fend.done && mode_q == PM_FULL && kind == FK_LONG)
                rec_cnt <= REC_W'(REC_CYCLES);
            else if (rec_cnt != '0)
                rec_cnt <= rec_cnt - 1'b1;
        end
    end

    assign mode   = mode_q;
    assign ref_en = (mode_q != PM_FULL);
    assign ready  = (mode_q != PM_FULL) && (rec_cnt == '0);

    AST_PPD_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (fend.done && mode_q == PM_NORMAL && fend.rises >= SMIN && fend.rises < LMIN)
        |=> mode_q == PM_PARTIAL);                                    // R3
    AST_FPD_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (fend.done && mode_q == PM_PARTIAL && fend.rises >= SMIN && fend.rises < LMIN)
        |=> (mode_q == PM_FULL && !ref_en && !ready));                // R5
    AST_FPD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (fend.done && mode_q == PM_FULL && fend.rises < LMIN)
        |=> mode_q == PM_FULL);                                       // R6
    AST_REC_START: assert property (@(posedge clk) disable iff (rst)
        (fend.done && mode_q == PM_FULL && fend.rises >= LMIN)
        |=> (mode_q == PM_NORMAL && ref_en && !ready));               // R7
endmodule

// File: rtl/adc_sif_ctrl.sv
module adc_sif_ctrl
    import adc_sif_pkg::*;
#(
    parameter int DATA_W      = 10,
    parameter int LEAD_BITS   = 3,
    parameter int FRAME_LEN   = 16,
    parameter int SHORT_MIN   = 4,
    parameter int LONG_MIN    = 14,
    parameter int REC_CYCLES  = 200000,
    parameter bit BIPOLAR     = 1'b0,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cnv_n,
    input  logic              sck,
    input  logic [DATA_W-1:0] sample,
    output logic              sdo,
    output logic              sdo_oe,
    output logic [1:0]        mode,
    output logic              ref_en,
    output logic              ready
);
    logic [1:0] lvl, rse, fll;
    frame_end_t fend;
    pmode_e     pm;

    adc_sif_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b10)) u_sync (
        .clk(clk), .rst(rst), .din({cnv_n, sck}),
        .level(lvl), .rise(rse), .fall(fll)
    );

    adc_sif_frame #(
        .DATA_W(DATA_W), .LEAD_BITS(LEAD_BITS),
        .FRAME_LEN(FRAME_LEN), .BIPOLAR(BIPOLAR)
    ) u_frame (
        .clk(clk), .rst(rst),
        .cs_rise(rse[1]), .cs_fall(fll[1]),
        .sck_rise(rse[0]), .sck_fall(fll[0]),
        .sample(sample), .invalid(!ready),
        .sdo(sdo), .sdo_oe(sdo_oe), .fend(fend)
    );

    adc_sif_pwr #(
        .SHORT_MIN(SHORT_MIN), .LONG_MIN(LONG_MIN), .REC_CYCLES(REC_CYCLES)
    ) u_pwr (
        .clk(clk), .rst(rst), .fend(fend),
        .mode(pm), .ref_en(ref_en), .ready(ready)
    );

    assign mode = pm;

    AST_OE_CS_HIGH: assert property (@(posedge clk) disable iff (rst)
        (lvl[1] && $past(lvl[1])) |-> !sdo_oe);                       // R1
endmodule

// File: tb/adc_sif_ctrl_tb.sv
module adc_sif_ctrl_tb;
    localparam int REC = 400;
    localparam int HC  = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cnv_n = 1'b1;
    logic       sck = 1'b0;
    logic [9:0] sample = '0;
    logic       sdo_u, oe_u, ref_u, rdy_u;
    logic       sdo_b, oe_b, ref_b, rdy_b;
    logic [1:0] mode_u, mode_b;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    adc_sif_ctrl #(.REC_CYCLES(REC), .BIPOLAR(1'b0)) u_dut (
        .clk(clk), .rst(rst), .cnv_n(cnv_n), .sck(sck), .sample(sample),
        .sdo(sdo_u), .sdo_oe(oe_u), .mode(mode_u), .ref_en(ref_u), .ready(rdy_u));

    adc_sif_ctrl #(.REC_CYCLES(REC), .BIPOLAR(1'b1)) u_dut_bip (
        .clk(clk), .rst(rst), .cnv_n(cnv_n), .sck(sck), .sample(sample),
        .sdo(sdo_b), .sdo_oe(oe_b), .mode(mode_b), .ref_en(ref_b), .ready(rdy_b));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        cnv_n = 1'b1; sck = 1'b0; rst = 1'b1;
        wclk(5);
        rst = 1'b0;
        wclk(4);
    endtask

    function automatic logic [15:0] exp_word(input logic [9:0] c, input bit inv);
        return {3'b000, c, inv, 2'b00};
    endfunction

    // Opens a frame, gives nr serial clocks, checks each bit read, then closes the frame.
    task automatic do_frame(input logic [9:0] smp, input int nr, input bit inv);
        logic [15:0] eu, eb;
        eu = exp_word(smp, inv);
        eb = exp_word(smp ^ 10'h200, inv);
        sample = smp;
        cnv_n = 1'b0;
        wclk(HC);
        sample = ~smp;  // R10: a change after capture must not reach the line
        chk(oe_u && oe_b, "R1 oe in frame", {oe_u, oe_b}, 3);
        for (int i = 0; i < nr; i++) begin
            int p;
            p = (i < 16) ? i : 16;
            if (p < 16) begin
                chk(sdo_u == eu[15-p], "R2/R8/R10 unipolar bit", sdo_u, eu[15-p]);
                chk(sdo_b == eb[15-p], "R9 bipolar bit", sdo_b, eb[15-p]);
            end else begin
                chk(sdo_u == 1'b0, "R2 past end", sdo_u, 0);
            end
            sck = 1'b1; wclk(HC);
            sck = 1'b0; wclk(HC);
        end
        cnv_n = 1'b1;
        wclk(HC);
        chk(!oe_u && !oe_b, "R1 oe after close", {oe_u, oe_b}, 0);
    endtask

    task automatic chk_state(input string req, input int m, input bit rf, input bit rd);
        chk(mode_u == 2'(m) && mode_b == 2'(m), req, mode_u, m);
        chk(ref_u == rf, req, ref_u, rf);
        chk(rdy_u == rd, req, rdy_u, rd);
    endtask

    initial begin
        do_reset();
        chk_state("R12 reset", 0, 1'b1, 1'b1);
        chk(!oe_u && !oe_b, "R12 reset oe", oe_u, 0);

        // R2 R9 R10: coding sweep of normal frames
        for (int k = 0; k < 1024; k += 5) do_frame(10'(k), 16, 1'b0);
        do_frame(10'h3FF, 16, 1'b0);
        do_frame(10'h200, 16, 1'b0);
        do_frame(10'h1FF, 16, 1'b0);
        do_frame(10'h001, 16, 1'b0);
        chk_state("R4 after long frames", 0, 1'b1, 1'b1);

        // Close-point sweep from normal: R3 R4
        for (int r = 0; r <= 16; r++) begin
            do_reset();
            do_frame(10'(37 * r + 5), r, 1'b0);
            if (r >= 4 && r <= 13) chk_state("R3 short from normal", 1, 1'b1, 1'b1);
            else                   chk_state("R4 normal kept", 0, 1'b1, 1'b1);
        end

        // Close-point sweep from partial: R5 R11
        for (int r = 0; r <= 16; r++) begin
            do_reset();
            do_frame(10'h155, 8, 1'b0);
            do_frame(10'(61 * r + 3), r, 1'b0);
            if (r >= 4 && r <= 13)  chk_state("R5 short from partial", 2, 1'b0, 1'b0);
            else if (r >= 14)       chk_state("R11 long from partial", 0, 1'b1, 1'b1);
            else                    chk_state("R11 partial kept", 1, 1'b1, 1'b1);
        end

        // Close-point sweep from full: R6 R7 R8
        for (int r = 0; r <= 16; r++) begin
            do_reset();
            do_frame(10'h0AA, 8, 1'b0);
            do_frame(10'h2AA, 8, 1'b0);
            do_frame(10'(83 * r + 9), r, 1'b1);
            if (r >= 14) chk_state("R7 exit full", 0, 1'b1, 1'b0);
            else         chk_state("R6 full kept", 2, 1'b0, 1'b0);
        end

        // Recovery window boundaries: R7
        do_reset();
        do_frame(10'h011, 6, 1'b0);
        do_frame(10'h022, 6, 1'b0);
        do_frame(10'h3C3, 14, 1'b1);
        wclk(REC - 20);
        chk(rdy_u == 1'b0, "R7 ready low before expiry", rdy_u, 0);
        wclk(30);
        chk(rdy_u == 1'b1 && rdy_b == 1'b1, "R7 ready after expiry", rdy_u, 1);

        // S1 during and after recovery: R8
        do_reset();
        do_frame(10'h011, 6, 1'b0);
        do_frame(10'h022, 6, 1'b0);
        do_frame(10'h123, 16, 1'b1);
        do_frame(10'h2B4, 16, 1'b1);  // opens while recovery runs
        wclk(REC);
        chk(rdy_u == 1'b1, "R8 ready after recovery", rdy_u, 1);
        do_frame(10'h2B4, 16, 1'b0);
        chk_state("R8 normal after recovery", 0, 1'b1, 1'b1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=complete");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule